// File: doc/BRIEF.md
# PWM Fault Trip Controller

This block sits on the path from a multi-channel PWM generator to the output pads. It watches a small set of external fault lines. Each line has its own enable, and any combination of lines may be armed at once. The first time an armed line is seen high, the block latches a trip. From then on it replaces the value and output-enable of every selected PWM pair with programmed safe states, and it raises a flag and an interrupt.

The trip is sticky. Nothing in hardware clears it. Only an explicit software write to the status address releases it. Because of this, noise on the fault lines after a trip can neither end the trip nor start a second one. The safe state is set globally. One level applies to all true outputs, a second level applies to all inverted outputs, and one bit chooses high impedance instead of a driven level.

Settings arrive on a single-cycle write port: a strobe, an address and data, with no back-pressure. PWM samples pass through combinationally every cycle, so there is no valid/ready handshake anywhere on the block.

Top module: `pwm_trip_guard`

## Requirements
- R1: After reset, and whenever no trip is latched, `trip_flag` and `trip_irq` are 0, every output-enable is 1, and each output equals its PWM input.
- R2: With exactly one fault line armed, a high level on that line sets `trip_flag` at the third rising clock edge after the line goes high. This covers two synchronizer flops and the latch.
- R3: A high level on a fault line whose arm bit is 0 never sets the flag. Arm bits are bits [N_SRC-1:0] of a write to address 0.
- R4: With several lines armed, a high level on any single armed line sets the flag.
- R5: Once set, the flag holds 1 regardless of later fault-line activity. It is cleared only by a write to address 2 with data bit 0 equal to 0. A write to address 2 with bit 0 equal to 1 has no effect.
- R6: If a clear write arrives in the same cycle as a synchronized armed fault, the set wins and the flag stays 1.
- R7: While tripped, with the tristate bit 0, each selected pair drives its true output to the true-level bit and its inverted output to the inverted-level bit, with output-enable 1. The true-level bit is bit N_SRC and the inverted-level bit is bit N_SRC+1 of an address-0 write.
- R8: While tripped, with the tristate bit 1, the output-enables of every selected pair are 0. The tristate bit is bit N_SRC+2 of an address-0 write.
- R9: While tripped, pairs whose select bit is 0 pass their inputs through with output-enable 1. Pair select bits are bits [N_PAIRS-1:0] of a write to address 1.
- R10: `trip_irq` equals `trip_flag` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_in | input | N_SRC | Asynchronous active-high fault lines |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Write address: 0 config, 1 pair select, 2 status |
| wr_data | input | DW | Write data |
| pwm_p_in | input | N_PAIRS | True PWM outputs from the generator |
| pwm_n_in | input | N_PAIRS | Inverted PWM outputs from the generator |
| pwm_p_out | output | N_PAIRS | True outputs to the pads |
| pwm_p_oe | output | N_PAIRS | Output-enables for the true pads |
| pwm_n_out | output | N_PAIRS | Inverted outputs to the pads |
| pwm_n_oe | output | N_PAIRS | Output-enables for the inverted pads |
| trip_flag | output | 1 | Latched trip indication |
| trip_irq | output | 1 | Interrupt request, level, equal to the flag |

## Verification
A fault line driven high is due at `trip_flag` on the third rising edge. The bench therefore checks that the flag is still 0 after two edges and is set after three. A write takes effect at the edge that samples it, so the bench drives writes and faults at falling edges and reads one falling edge later. The overrides are combinational from the flag and the settings, so their expected values are compared in that same half-cycle. The bench sweeps every arm mask against every fault line, and every combination of safe-state bits against every pair mask and several input patterns.

// File: rtl/trip_pkg.sv
package trip_pkg;
  localparam int unsigned AW = 2;
  localparam logic [AW-1:0] ADDR_CFG    = 2'd0;
  localparam logic [AW-1:0] ADDR_PAIRS  = 2'd1;
  localparam logic [AW-1:0] ADDR_STATUS = 2'd2;

  typedef struct packed {
    logic tri_sel;
    logic lvl_n;
    logic lvl_p;
  } safe_cfg_t;
endpackage

// File: rtl/trip_sync.sv
module trip_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/trip_regs.sv
module trip_regs
  import trip_pkg::*;
#(
  parameter int unsigned N_SRC   = 4,
  parameter int unsigned N_PAIRS = 4,
  parameter int unsigned DW      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  output logic [N_SRC-1:0]   src_en,
  output logic [N_PAIRS-1:0] pair_en,
  output safe_cfg_t          safe,
  output logic               clr_req
);
  localparam int unsigned SAFE_LSB = N_SRC;
  localparam int unsigned SAFE_W   = $bits(safe_cfg_t);

  logic wr_cfg, wr_pairs;
  assign wr_cfg   = wr_en && (wr_addr == ADDR_CFG);
  assign wr_pairs = wr_en && (wr_addr == ADDR_PAIRS);
  assign clr_req  = wr_en && (wr_addr == ADDR_STATUS) && !wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_en  <= '0;
      pair_en <= '0;
      safe    <= '0;
    end else begin
      if (wr_cfg) begin
        src_en <= wr_data[N_SRC-1:0];
        safe   <= safe_cfg_t'(wr_data[SAFE_LSB +: SAFE_W]);
      end
      if (wr_pairs) pair_en <= wr_data[N_PAIRS-1:0];
    end
  end
endmodule

// File: rtl/trip_latch.sv
module trip_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/trip_override.sv
module trip_override
  import trip_pkg::*;
#(
  parameter int unsigned N_PAIRS = 4
) (
  input  logic               tripped,
  input  logic [N_PAIRS-1:0] pair_en,
  input  safe_cfg_t          safe,
  input  logic [N_PAIRS-1:0] p_in,
  input  logic [N_PAIRS-1:0] n_in,
  output logic [N_PAIRS-1:0] p_out,
  output logic [N_PAIRS-1:0] p_oe,
  output logic [N_PAIRS-1:0] n_out,
  output logic [N_PAIRS-1:0] n_oe
);
  for (genvar i = 0; i < N_PAIRS; i++) begin : g_pair
    logic force_i;
    assign force_i  = tripped & pair_en[i];
    assign p_out[i] = force_i ? safe.lvl_p : p_in[i];
    assign n_out[i] = force_i ? safe.lvl_n : n_in[i];
    assign p_oe[i]  = ~(force_i & safe.tri_sel);
    assign n_oe[i]  = ~(force_i & safe.tri_sel);
  end
endmodule

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard
  import trip_pkg::*;
#(
  parameter int unsigned N_SRC       = 4,
  parameter int unsigned N_PAIRS     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DW          = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   fault_in,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [N_PAIRS-1:0] pwm_p_in,
  input  logic [N_PAIRS-1:0] pwm_n_in,
  output logic [N_PAIRS-1:0] pwm_p_out,
  output logic [N_PAIRS-1:0] pwm_p_oe,
  output logic [N_PAIRS-1:0] pwm_n_out,
  output logic [N_PAIRS-1:0] pwm_n_oe,
  output logic               trip_flag,
  output logic               trip_irq
);
  logic [N_SRC-1:0]   fault_s;
  logic [N_SRC-1:0]   src_en;
  logic [N_PAIRS-1:0] pair_en;
  safe_cfg_t          safe;
  logic               clr_req;
  logic               src_hit;
  logic               cfg_tri;

  trip_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(fault_in), .q(fault_s)
  );

  trip_regs #(.N_SRC(N_SRC), .N_PAIRS(N_PAIRS), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .src_en(src_en), .pair_en(pair_en),
    .safe(safe), .clr_req(clr_req)
  );

  assign src_hit = |(fault_s & src_en);
  assign cfg_tri = safe.tri_sel;

  trip_latch u_latch (
    .clk(clk), .rst_n(rst_n), .set_i(src_hit), .clr_i(clr_req),
    .flag_o(trip_flag)
  );

  assign trip_irq = trip_flag;

  trip_override #(.N_PAIRS(N_PAIRS)) u_ovr (
    .tripped(trip_flag), .pair_en(pair_en), .safe(safe),
    .p_in(pwm_p_in), .n_in(pwm_n_in),
    .p_out(pwm_p_out), .p_oe(pwm_p_oe),
    .n_out(pwm_n_out), .n_oe(pwm_n_oe)
  );
endmodule

// File: rtl/pwm_trip_guard_chk.sv
module pwm_trip_guard_chk #(
  parameter int unsigned N_PAIRS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flag,
  input logic               src_hit,
  input logic               clr_req,
  input logic               cfg_tri,
  input logic [N_PAIRS-1:0] pair_en,
  input logic [N_PAIRS-1:0] p_in,
  input logic [N_PAIRS-1:0] p_out,
  input logic [N_PAIRS-1:0] p_oe,
  input logic [N_PAIRS-1:0] n_oe
);
  AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    src_hit |=> flag); // R2
  AST_RISE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(src_hit)); // R3
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag); // R5
  AST_SET_OVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && src_hit) |=> flag); // R6
  AST_TRI_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && cfg_tri) |-> (((p_oe | n_oe) & pair_en) == '0)); // R8
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |-> (p_out == p_in && p_oe == '1 && n_oe == '1)); // R1
endmodule

bind pwm_trip_guard pwm_trip_guard_chk #(.N_PAIRS(N_PAIRS)) u_chk (
  .clk(clk), .rst_n(rst_n), .flag(trip_flag), .src_hit(src_hit),
  .clr_req(clr_req), .cfg_tri(cfg_tri), .pair_en(pair_en),
  .p_in(pwm_p_in), .p_out(pwm_p_out), .p_oe(pwm_p_oe), .n_oe(pwm_n_oe)
);

// File: tb/pwm_trip_guard_test.sv
module pwm_trip_guard_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] fault_in = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] pwm_p_in = '0, pwm_n_in = '0;
  logic [3:0] pwm_p_out, pwm_p_oe, pwm_n_out, pwm_n_oe;
  logic       trip_flag, trip_irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_trip_guard uut (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_p_in(pwm_p_in),
    .pwm_n_in(pwm_n_in), .pwm_p_out(pwm_p_out), .pwm_p_oe(pwm_p_oe),
    .pwm_n_out(pwm_n_out), .pwm_n_oe(pwm_n_oe), .trip_flag(trip_flag),
    .trip_irq(trip_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // config word: [3:0] arm, [4] true level, [5] inverted level, [6] tristate
  task automatic trip_once();
    @(negedge clk); fault_in = 4'b0001;
    idle(3);
    fault_in = '0;
    idle(3);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    pwm_p_in = 4'hA; pwm_n_in = 4'h5;
    @(negedge clk);
    check("R1", trip_flag, 0);
    check("R10", trip_irq, 0);
    check("R1", pwm_p_out, 4'hA);
    check("R1", pwm_n_out, 4'h5);
    check("R1", {pwm_p_oe, pwm_n_oe}, 8'hFF);

    // arm mask x fault line sweep
    for (int m = 0; m < 16; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic exp_set;
        string tag;
        exp_set = m[s];
        tag = !exp_set ? "R3" : ($countones(m) == 1 ? "R2" : "R4");
        write(2'd0, 8'(m));
        write(2'd2, 8'h00);
        @(negedge clk); fault_in = 4'(1 << s);
        idle(2);
        check(tag, trip_flag, 0);
        idle(1);
        check(tag, trip_flag, 32'(exp_set));
        fault_in = '0;
        idle(4);
        check("R5", trip_flag, 32'(exp_set));
        check("R10", trip_irq, 32'(trip_flag));
        write(2'd2, 8'h00);
        check("R5", trip_flag, 0);
      end
    end

    // glitches after a trip, and ignored status writes
    write(2'd0, 8'h01);
    trip_once();
    for (int g = 0; g < 6; g++) begin
      @(negedge clk); fault_in = 4'(g[0] ? 4'hF : 4'h0);
    end
    fault_in = '0; idle(3);
    check("R5", trip_flag, 1);
    write(2'd2, 8'h01);
    check("R5", trip_flag, 1);
    write(2'd2, 8'h00);
    check("R5", trip_flag, 0);

    // clear while an armed fault is still high
    @(negedge clk); fault_in = 4'b0001;
    idle(3);
    write(2'd2, 8'h00);
    check("R6", trip_flag, 1);
    fault_in = '0; idle(3);
    write(2'd2, 8'h00);
    check("R6", trip_flag, 0);

    // safe-state sweep
    trip_once();
    for (int c = 0; c < 8; c++) begin
      for (int m = 0; m < 16; m++) begin
        write(2'd0, 8'({c[2:0], 4'b0001}));
        write(2'd1, 8'(m));
        for (int pat = 0; pat < 4; pat++) begin
          logic [3:0] mk, pi, ni, lp, ln;
          logic tri_b;
          mk = 4'(m);
          pi = 4'(pat * 5 + 3); ni = ~pi;
          lp = {4{c[0]}}; ln = {4{c[1]}}; tri_b = c[2];
          pwm_p_in = pi; pwm_n_in = ni;
          #1;
          check("R7", pwm_p_out & mk, lp & mk);
          check("R7", pwm_n_out & mk, ln & mk);
          check(tri_b ? "R8" : "R7", {pwm_p_oe & mk, pwm_n_oe & mk},
                tri_b ? 8'h00 : {mk, mk});
          check("R9", {pwm_p_out & ~mk, pwm_n_out & ~mk}, {pi & ~mk, ni & ~mk});
          check("R9", {pwm_p_oe & ~mk, pwm_n_oe & ~mk}, {~mk, ~mk});
        end
      end
    end
    check("R5", trip_flag, 1);

    // release: everything passes through again
    write(2'd2, 8'h00);
    for (int pat = 0; pat < 16; pat++) begin
      pwm_p_in = 4'(pat); pwm_n_in = 4'(15 - pat);
      #1;
      check("R1", {pwm_p_out, pwm_n_out}, {4'(pat), 4'(15 - pat)});
      check("R1", {pwm_p_oe, pwm_n_oe}, 8'hFF);
    end
    check("R10", trip_irq, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule